// File: doc/BRIEF.md
# Inline Memory Data Scrambler

This block sits in series with the data lines between a host memory controller and DRAM devices. Every 64-bit write beat is XORed with a keystream word before it reaches DRAM. Every read beat coming back from DRAM is XORed with the same keystream word for the same column before it returns to the host, so a round trip gives back the original data. The keystream word for a beat depends on a volatile 64-bit key and on the beat's column address. As a result, a region full of zeros does not store the key itself.

The key lives only in flip-flops. After reset it is built from four 16-bit words taken from a random-number port. It is wiped as soon as a tamper input fires or power-good drops, and it stays wiped until the next reset. While no key is loaded, scrambled data paths emit all-zero data, so plaintext never passes through. Both data paths and the command forwarded to DRAM carry exactly two register stages, which fits the extra cycle of a registered-module timing slot. Within a burst of four, the beat addresses come from counters seeded by the column captured with each command.

Top module: `mem_scrambler`

## Requirements
- R1: A host write beat (`host_wr_valid` high) appears on `dram_wdata` as the host word XOR the keystream word of the beat's column, provided the key was ready when the beat was taken.
- R2: A DRAM read beat (`dram_rd_valid` high) appears on `host_rdata` as the DRAM word XOR the same keystream function. Reading back the scrambled words of a region therefore returns the original data.
- R3: Both data paths have a latency of exactly two clock cycles. A beat sampled at clock edge k drives its output valid and data after edge k+2. When an output valid is low, its data is all zero.
- R4: The keystream word for column c is key XOR rotate_left_23((c + 1) * 0x9E3779B97F4A7C15 mod 2^64), with c zero-extended to 64 bits. All-zero data written to two different columns gives two different stored words.
- R5: A command (`host_cmd_valid`; `host_cmd_write` = 1 for write, 0 for read) captures its column for that direction. The beats of that direction then use columns c, c+1, c+2, c+3, modulo 2^10, and a fifth beat returns to c. A beat in the same cycle as its command uses the new column. Read and write keep separate counters.
- R6: The key loads from four accepted 16-bit random words. The first word goes to key bits 15:0, the next to bits 31:16, and so on. A word is accepted when `rng_valid` and `rng_ready` are both high. `key_ready` rises in the cycle after the fourth acceptance, and `rng_ready` then falls.
- R7: A beat taken while `key_ready` is low leaves the block as all-zero data. Its valid strobe still passes through.
- R8: If `tamper` is high or `pwr_good` is low at a clock edge, then after that edge the key is zero and `key_ready` and `rng_ready` are both low.
- R9: After a wipe, words presented on the random port are refused and `key_ready` stays low until `rst_n` is asserted.
- R10: After reset, `key_ready`, all valid outputs and all data outputs are zero, and `rng_ready` is high.
- R11: A host command appears on `dram_cmd_valid`, `dram_cmd_write` and `dram_cmd_col` exactly two cycles after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cmd_valid | input | 1 | Host command strobe |
| host_cmd_write | input | 1 | 1 = write command, 0 = read command |
| host_cmd_col | input | 10 | Starting column of the burst |
| host_wr_valid | input | 1 | Host write beat strobe |
| host_wdata | input | 64 | Host write beat data |
| host_rd_valid | output | 1 | Descrambled read beat strobe |
| host_rdata | output | 64 | Descrambled read beat data |
| dram_cmd_valid | output | 1 | Forwarded command strobe |
| dram_cmd_write | output | 1 | Forwarded command direction |
| dram_cmd_col | output | 10 | Forwarded command column |
| dram_wr_valid | output | 1 | Scrambled write beat strobe |
| dram_wdata | output | 64 | Scrambled write beat data |
| dram_rd_valid | input | 1 | DRAM read beat strobe |
| dram_rdata | input | 64 | DRAM read beat data |
| rng_valid | input | 1 | Random word offered |
| rng_word | input | 16 | Random word |
| rng_ready | output | 1 | Random word will be accepted |
| tamper | input | 1 | Tamper indication, wipes key |
| pwr_good | input | 1 | Power good; low wipes key |
| key_ready | output | 1 | Key loaded and valid |

## Verification
Write bursts of all-zero data at a column range that wraps past the top of the column space show two things. First, the keystream changes with the column. Second, the burst counter wraps both in address and, on a fifth beat, back to the start. Random data bursts, some issued with the command in the same cycle as the first beat and some with a gap, separate correct counter seeding from a counter that only steps. Feeding the scrambled words back as read data must give zeros to the host, which shows the two paths use the same function. Nonzero data sent before key load and after tamper or power loss must come out as zeros, which catches any path that leaks plaintext when no key is present.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DATA_W    = 64;
  localparam int RNG_W     = 16;
  localparam int KEY_WORDS = DATA_W / RNG_W;
  localparam int KCNT_W    = $clog2(KEY_WORDS + 1);
  localparam int COL_W     = 10;
  localparam int BURST_LEN = 4;
  localparam int BIDX_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int MIX_ROT   = 23;
  localparam logic [DATA_W-1:0] MIX_MUL = 64'h9E3779B97F4A7C15;

  // keystream word for one column: key mixed with a spread copy of the column
  function automatic logic [DATA_W-1:0] mix_keystream(
    input logic [DATA_W-1:0] key,
    input logic [COL_W-1:0]  col
  );
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] p;
    a = DATA_W'(col) + DATA_W'(1);
    p = a * MIX_MUL;
    return key ^ ((p << MIX_ROT) | (p >> (DATA_W - MIX_ROT)));
  endfunction
endpackage

// File: rtl/scr_key_vault.sv
module scr_key_vault
  import scr_pkg::*;
#(
  parameter int KW = DATA_W,
  parameter int RW = RNG_W,
  localparam int NWORDS = KW / RW,
  localparam int CW = $clog2(NWORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tamper,
  input  logic          pwr_good,
  input  logic          rng_valid,
  input  logic [RW-1:0] rng_word,
  output logic          rng_ready,
  output logic [KW-1:0] key,
  output logic          key_ready,
  output logic          wipe_evt,
  output logic          load_accept
);
  logic [CW-1:0] cnt;
  logic          wiped;

  assign wipe_evt    = tamper | ~pwr_good;
  assign rng_ready   = ~wiped & (cnt < CW'(NWORDS));
  assign load_accept = rng_valid & rng_ready & ~wipe_evt;
  assign key_ready   = ~wiped & (cnt == CW'(NWORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key   <= '0;
      cnt   <= '0;
      wiped <= 1'b0;
    end else if (wipe_evt) begin
      key   <= '0;
      cnt   <= '0;
      wiped <= 1'b1;
    end else if (load_accept) begin
      key[cnt*RW +: RW] <= rng_word;
      cnt               <= cnt + CW'(1);
    end
  end

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_evt |=> (key == '0 && !key_ready && !rng_ready)); // R8
  AST_WIPE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wiped |=> (!key_ready && !rng_ready)); // R9
  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_ready) |-> ($past(load_accept) && $past(cnt) == CW'(NWORDS - 1))); // R6
endmodule

// File: rtl/scr_beat_addr.sv
module scr_beat_addr
  import scr_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int BL = BURST_LEN,
  localparam int IW = (BL > 1) ? $clog2(BL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_hit,
  input  logic [CW-1:0] cmd_col,
  input  logic          beat,
  output logic [CW-1:0] beat_col,
  output logic [IW-1:0] beat_idx
);
  logic [CW-1:0] base;
  logic [IW-1:0] idx;
  logic [IW-1:0] idx_next;

  assign beat_idx = cmd_hit ? '0 : idx;
  assign beat_col = cmd_hit ? cmd_col : base + CW'(idx);
  assign idx_next = (beat_idx == IW'(BL - 1)) ? '0 : beat_idx + IW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      idx  <= '0;
    end else begin
      if (cmd_hit) base <= cmd_col;
      if (beat) idx <= idx_next;
      else if (cmd_hit) idx <= '0;
    end
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !cmd_hit && $past(beat) && $past(beat_idx) != IW'(BL - 1))
      |-> beat_col == $past(beat_col) + CW'(1)); // R5
endmodule

// File: rtl/scr_xor_pipe.sv
module scr_xor_pipe
  import scr_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int CW = COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [CW-1:0] in_col,
  input  logic [W-1:0]  key,
  input  logic          key_ok,
  output logic          out_valid,
  output logic [W-1:0]  out_data
);
  logic          s1_valid;
  logic          s1_ok;
  logic [W-1:0]  s1_data;
  logic [W-1:0]  s1_ks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_ok     <= 1'b0;
      s1_data   <= '0;
      s1_ks     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      s1_valid  <= in_valid;
      s1_ok     <= key_ok;
      s1_data   <= in_data;
      s1_ks     <= mix_keystream(key, in_col);
      out_valid <= s1_valid;
      out_data  <= (s1_valid && s1_ok) ? (s1_data ^ s1_ks) : '0;
    end
  end

  AST_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R3
  AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !key_ok) |-> ##2 (out_data == '0)); // R7
endmodule

// File: rtl/mem_scrambler.sv
module mem_scrambler
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cmd_valid,
  input  logic              host_cmd_write,
  input  logic [COL_W-1:0]  host_cmd_col,
  input  logic              host_wr_valid,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rd_valid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dram_cmd_valid,
  output logic              dram_cmd_write,
  output logic [COL_W-1:0]  dram_cmd_col,
  output logic              dram_wr_valid,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic              dram_rd_valid,
  input  logic [DATA_W-1:0] dram_rdata,
  input  logic              rng_valid,
  input  logic [RNG_W-1:0]  rng_word,
  output logic              rng_ready,
  input  logic              tamper,
  input  logic              pwr_good,
  output logic              key_ready
);
  logic [DATA_W-1:0] key;
  logic              wipe_evt;
  logic              load_accept;
  logic              wr_cmd_hit, rd_cmd_hit;
  logic [COL_W-1:0]  wr_col, rd_col;
  logic [BIDX_W-1:0] wr_idx, rd_idx;
  logic [1:0]              cmd_v_q, cmd_w_q;
  logic [1:0][COL_W-1:0]   cmd_c_q;

  assign wr_cmd_hit = host_cmd_valid & host_cmd_write;
  assign rd_cmd_hit = host_cmd_valid & ~host_cmd_write;

  scr_key_vault u_vault (
    .clk(clk), .rst_n(rst_n), .tamper(tamper), .pwr_good(pwr_good),
    .rng_valid(rng_valid), .rng_word(rng_word), .rng_ready(rng_ready),
    .key(key), .key_ready(key_ready), .wipe_evt(wipe_evt),
    .load_accept(load_accept)
  );

  scr_beat_addr u_wr_addr (
    .clk(clk), .rst_n(rst_n), .cmd_hit(wr_cmd_hit), .cmd_col(host_cmd_col),
    .beat(host_wr_valid), .beat_col(wr_col), .beat_idx(wr_idx)
  );

  scr_beat_addr u_rd_addr (
    .clk(clk), .rst_n(rst_n), .cmd_hit(rd_cmd_hit), .cmd_col(host_cmd_col),
    .beat(dram_rd_valid), .beat_col(rd_col), .beat_idx(rd_idx)
  );

  scr_xor_pipe u_wr_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(host_wr_valid), .in_data(host_wdata),
    .in_col(wr_col), .key(key), .key_ok(key_ready),
    .out_valid(dram_wr_valid), .out_data(dram_wdata)
  );

  scr_xor_pipe u_rd_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(dram_rd_valid), .in_data(dram_rdata),
    .in_col(rd_col), .key(key), .key_ok(key_ready),
    .out_valid(host_rd_valid), .out_data(host_rdata)
  );

  // command forwarding matched to the data path depth
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_v_q <= '0;
      cmd_w_q <= '0;
      cmd_c_q <= '0;
    end else begin
      cmd_v_q <= {cmd_v_q[0], host_cmd_valid};
      cmd_w_q <= {cmd_w_q[0], host_cmd_write};
      cmd_c_q <= {cmd_c_q[0], host_cmd_col};
    end
  end

  assign dram_cmd_valid = cmd_v_q[1];
  assign dram_cmd_write = cmd_w_q[1];
  assign dram_cmd_col   = cmd_c_q[1];

  AST_CMD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    host_cmd_valid |-> ##2 (dram_cmd_valid && dram_cmd_col == $past(host_cmd_col, 2))); // R11
  AST_NO_KEY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_rd_valid && !key_ready) |-> ##2 (host_rdata == '0)); // R7
endmodule

// File: tb/sim_mem_scrambler.sv
`timescale 1ns/1ps
module sim_mem_scrambler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cmd_valid = 0, host_cmd_write = 0;
  logic [9:0]  host_cmd_col = '0;
  logic        host_wr_valid = 0;
  logic [63:0] host_wdata = '0;
  logic        host_rd_valid;
  logic [63:0] host_rdata;
  logic        dram_cmd_valid, dram_cmd_write;
  logic [9:0]  dram_cmd_col;
  logic        dram_wr_valid;
  logic [63:0] dram_wdata;
  logic        dram_rd_valid = 0;
  logic [63:0] dram_rdata = '0;
  logic        rng_valid = 0;
  logic [15:0] rng_word = '0;
  logic        rng_ready;
  logic        tamper = 0, pwr_good = 1;
  logic        key_ready;

  always #2.5 clk = ~clk;

  mem_scrambler u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] ref_ks(logic [63:0] k, int c);
    logic [63:0]  p;
    logic [127:0] d;
    p = (64'(c & 1023) + 64'd1) * 64'h9E3779B97F4A7C15;
    d = {p, p} << 23;
    return k ^ d[127:64];
  endfunction

  // reference model, updated on the clock from sampled inputs
  logic [63:0] m_key;
  int          m_cnt, wbase, widx, rbase, ridx;
  bit          m_wiped;
  bit          s_wv, s_wok, s_rv, s_rok;
  logic [63:0] s_wd, s_wk, s_rd, s_rk;
  int          s_wc, s_rc;
  bit          e_wv, e_rv;
  logic [63:0] e_wd, e_rd;
  int          q_cv[2], q_cw[2], q_cc[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_key <= '0; m_cnt <= 0; m_wiped <= 0;
      wbase <= 0; widx <= 0; rbase <= 0; ridx <= 0;
      s_wv <= 0; s_rv <= 0; s_wok <= 0; s_rok <= 0;
      s_wd <= '0; s_rd <= '0; s_wk <= '0; s_rk <= '0; s_wc <= 0; s_rc <= 0;
      e_wv <= 0; e_rv <= 0; e_wd <= '0; e_rd <= '0;
      q_cv <= '{0, 0}; q_cw <= '{0, 0}; q_cc <= '{0, 0};
    end else begin
      int  wi, ri, wc, rc;
      bit  wcmd, rcmd;
      wcmd = host_cmd_valid && host_cmd_write;
      rcmd = host_cmd_valid && !host_cmd_write;
      wi = wcmd ? 0 : widx;
      ri = rcmd ? 0 : ridx;
      wc = wcmd ? int'(host_cmd_col) : (wbase + wi) % 1024;
      rc = rcmd ? int'(host_cmd_col) : (rbase + ri) % 1024;
      e_wv <= s_wv; e_wd <= (s_wv && s_wok) ? (s_wd ^ ref_ks(s_wk, s_wc)) : 64'd0;
      e_rv <= s_rv; e_rd <= (s_rv && s_rok) ? (s_rd ^ ref_ks(s_rk, s_rc)) : 64'd0;
      s_wv <= host_wr_valid; s_wd <= host_wdata; s_wk <= m_key; s_wc <= wc;
      s_wok <= (m_cnt == 4) && !m_wiped;
      s_rv <= dram_rd_valid; s_rd <= dram_rdata; s_rk <= m_key; s_rc <= rc;
      s_rok <= (m_cnt == 4) && !m_wiped;
      if (wcmd) wbase <= int'(host_cmd_col);
      if (host_wr_valid) widx <= (wi + 1) % 4; else if (wcmd) widx <= 0;
      if (rcmd) rbase <= int'(host_cmd_col);
      if (dram_rd_valid) ridx <= (ri + 1) % 4; else if (rcmd) ridx <= 0;
      q_cv[1] <= q_cv[0]; q_cw[1] <= q_cw[0]; q_cc[1] <= q_cc[0];
      q_cv[0] <= host_cmd_valid; q_cw[0] <= host_cmd_write; q_cc[0] <= host_cmd_col;
      if (tamper || !pwr_good) begin
        m_key <= '0; m_cnt <= 0; m_wiped <= 1;
      end else if (rng_valid && !m_wiped && m_cnt < 4) begin
        m_key[m_cnt*16 +: 16] <= rng_word;
        m_cnt <= m_cnt + 1;
      end
    end
  end

  logic [63:0] wq[$];
  logic [63:0] rq[$];

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 dram_wdata", dram_wdata, e_wd);
      chk("R2 host_rdata", host_rdata, e_rd);
      chk("R3 valids", {62'd0, dram_wr_valid, host_rd_valid}, {62'd0, e_wv, e_rv});
      chk("R6 key_ready/rng_ready", {62'd0, key_ready, rng_ready},
          {62'd0, (m_cnt == 4) && !m_wiped, !m_wiped && m_cnt < 4});
      chk("R11 dram_cmd", {52'd0, dram_cmd_valid, dram_cmd_write, dram_cmd_col},
          {52'd0, 1'(q_cv[1]), 1'(q_cw[1]), 10'(q_cc[1])});
      if (dram_wr_valid) wq.push_back(dram_wdata);
      if (host_rd_valid) rq.push_back(host_rdata);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_burst(int col, int n, bit zero, bit split);
    if (split) begin
      @(negedge clk);
      host_cmd_valid = 1; host_cmd_write = 1; host_cmd_col = 10'(col);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_cmd_valid = (!split && i == 0); host_cmd_write = 1; host_cmd_col = 10'(col);
      host_wr_valid = 1;
      host_wdata = zero ? 64'd0 : {$urandom, $urandom};
    end
    @(negedge clk);
    host_cmd_valid = 0; host_wr_valid = 0; host_wdata = '0;
  endtask

  task automatic rd_burst(int col, int n, bit from_wq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_cmd_valid = (i == 0); host_cmd_write = 0; host_cmd_col = 10'(col);
      dram_rd_valid = 1;
      dram_rdata = from_wq ? wq[i] : {$urandom, $urandom};
    end
    @(negedge clk);
    host_cmd_valid = 0; dram_rd_valid = 0; dram_rdata = '0;
  endtask

  task automatic load_key(logic [63:0] k, bit gaps);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rng_valid = 1; rng_word = k[i*16 +: 16];
      if (gaps) begin @(negedge clk); rng_valid = 0; end
    end
    @(negedge clk);
    rng_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    idle(3);
    rst_n = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [63:0] K1 = 64'h4444_3333_2222_1111;
  localparam logic [63:0] K2 = 64'h0F1E_2D3C_4B5A_6978;

  initial begin
    logic [63:0] w0;
    idle(4);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 key_ready", {63'd0, key_ready}, 64'd0);
    chk("R10 rng_ready", {63'd0, rng_ready}, 64'd1);
    chk("R10 outputs", {60'd0, dram_wr_valid, host_rd_valid, dram_cmd_valid, 1'b0} | dram_wdata | host_rdata, 64'd0);

    // R7 nonzero data before key load leaves as zeros
    wq.delete();
    wr_burst(12, 4, 0, 0);
    idle(3);
    chk("R7 locked burst count", 64'(wq.size()), 64'd4);
    foreach (wq[i]) chk("R7 locked data zero", wq[i], 64'd0);

    // R6 key load with gaps
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rng_valid = 1; rng_word = K1[i*16 +: 16];
      @(negedge clk); rng_valid = 0;
    end
    chk("R6 not ready after three words", {63'd0, key_ready}, 64'd0);
    rng_valid = 1; rng_word = K1[63:48];
    @(negedge clk); rng_valid = 0;
    chk("R6 ready after fourth word", {62'd0, key_ready, rng_ready}, 64'd2);
    // extra words refused while loaded
    @(negedge clk); rng_valid = 1; rng_word = 16'hDEAD;
    @(negedge clk); rng_valid = 0;

    // R3 exact latency
    @(negedge clk); host_wr_valid = 1; host_wdata = 64'h1;
    host_cmd_valid = 1; host_cmd_write = 1; host_cmd_col = 10'd7;
    @(negedge clk); host_wr_valid = 0; host_cmd_valid = 0;
    chk("R3 not valid after one cycle", {63'd0, dram_wr_valid}, 64'd0);
    @(negedge clk);
    chk("R3 valid after two cycles", {63'd0, dram_wr_valid}, 64'd1);
    chk("R1 single beat value", dram_wdata, 64'h1 ^ ref_ks(K1, 7));

    // R4 and R5: zero burst across the top column, five beats
    idle(2);
    wq.delete();
    wr_burst(10'h3FE, 5, 1, 0);
    idle(3);
    chk("R5 five beats", 64'(wq.size()), 64'd5);
    if (wq.size() == 5) begin
      chk("R4 keystream col 3FE", wq[0], ref_ks(K1, 10'h3FE));
      chk("R4 differs across columns", {63'd0, wq[0] != wq[1]}, 64'd1);
      chk("R5 wrap to col 0", wq[2], ref_ks(K1, 0));
      chk("R5 fifth beat back to start", wq[4], ref_ks(K1, 10'h3FE));
      // R2 round trip
      rq.delete();
      rd_burst(10'h3FE, 4, 1);
      idle(3);
      chk("R2 round trip count", 64'(rq.size()), 64'd4);
      foreach (rq[i]) chk("R2 round trip zero", rq[i], 64'd0);
    end

    // R5 command separated from its beats, and random traffic
    for (int b = 0; b < 6; b++) begin
      wr_burst($urandom % 1024, 4, 0, b[0]);
      rd_burst($urandom % 1024, 4, 0);
    end
    idle(3);
    w0 = ref_ks(K1, 100);
    wq.delete();
    wr_burst(100, 1, 1, 1);
    idle(3);
    chk("R5 split command seeds column", (wq.size() > 0) ? wq[0] : 64'hX, w0);

    // R8 tamper wipes, R9 stays wiped
    @(negedge clk); tamper = 1;
    @(negedge clk); tamper = 0;
    chk("R8 tamper clears ready", {62'd0, key_ready, rng_ready}, 64'd0);
    load_key(K2, 0);
    chk("R9 refill refused", {62'd0, key_ready, rng_ready}, 64'd0);
    wq.delete();
    wr_burst(40, 4, 0, 0);
    idle(3);
    foreach (wq[i]) chk("R9 data zero after wipe", wq[i], 64'd0);

    // reset, reload new key, then power-good loss
    do_reset();
    @(negedge clk);
    chk("R10 ready again after reset", {62'd0, key_ready, rng_ready}, 64'd1);
    load_key(K2, 0);
    chk("R6 reload", {63'd0, key_ready}, 64'd1);
    wq.delete();
    wr_burst(3, 1, 1, 0);
    idle(3);
    chk("R4 new key keystream", (wq.size() > 0) ? wq[0] : 64'hX, ref_ks(K2, 3));
    @(negedge clk); pwr_good = 0;
    @(negedge clk); pwr_good = 1;
    chk("R8 power loss clears ready", {62'd0, key_ready, rng_ready}, 64'd0);
    rq.delete();
    rd_burst(9, 4, 0);
    idle(3);
    foreach (rq[i]) chk("R9 read zero after power loss", rq[i], 64'd0);
    idle(2);
    finish_run();
  end
endmodule